// File: doc/BRIEF.md
# Interrupt Distributor Control Registers

A register slave for the global part of a shared-interrupt distributor. It holds the distributor control register, which has a stored group-1 enable and two flag bits that are always set. It also holds a type register, computed from parameters, that reports the line count, the interrupt ID width and LPI support. An identification register, a small peripheral-ID window and one 64-bit routing register per shared interrupt complete the set. Each routing register holds a 24-bit target affinity.

Requests arrive on a simple single-cycle bus with a byte address, a 32-bit or 64-bit size and a write flag. Every request is answered exactly one cycle later. When software turns the distributor on, the block raises a one-cycle kick pulse so that downstream logic can re-evaluate pending interrupts.

Top module: `irq_dist_ctrl_regs`

## Requirements
- R1: The control register is at offset 0x000. Only bit 1 (group-1 enable) is stored. Bits 4 and 6 always read as one, and every other bit reads as zero. After reset it reads 0x50.
- R2: A write to the control register that takes bit 1 from 0 to 1 raises `kick` for exactly one cycle, in the same cycle as the response. Writing 1 while already enabled raises no pulse.
- R3: Writing 0 to bit 1 disables the distributor and raises no pulse.
- R4: The type register is at offset 0x004. Bits 4:0 read (NUM_SHARED + 32) / 32 - 1.
- R5: Type bits 23:19 read the ID width minus one: 15 when LPI_EN is 1 and 9 otherwise. Bit 17 reads LPI_EN.
- R6: The ID register is at offset 0x008 and reads {PRODUCT, 12'h000, IMPLEMENTER}. Writes to the type and ID registers have no effect.
- R7: The routing register for interrupt n (32 <= n < 32+NUM_SHARED) is at 0x6000 + 8*n. A write that covers its lower word stores data bits 23:0, and reads return the stored bits with bits 31:24 zero.
- R8: The upper word (+4) of a routing register reads zero, and a 32-bit write to it is ignored. A 64-bit write stores only bits 23:0.
- R9: The routing slots for n < 32 and n >= 32+NUM_SHARED read zero and ignore writes.
- R10: Offset 0xFFE8 reads 0x3B. All other unmapped offsets, including the rest of 0xFFD0..0xFFFC, read zero.
- R11: A 64-bit access addresses an 8-byte slot. A 32-bit read returns the addressed word right-aligned, with bits 63:32 zero, and a 64-bit read at 0x000 returns {type, control}.
- R12: `resp_valid` is high exactly in the cycle after each request. `resp_rdata` is zero for writes.
- R13: Reset clears the enable and all routing registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit |
| req_addr | input | ADDR_W | Byte offset |
| req_wdata | input | 64 | Write data (32-bit writes use bits 31:0) |
| resp_valid | output | 1 | Response for the previous cycle's request |
| resp_rdata | output | 64 | Read data, right-aligned |
| kick | output | 1 | One-cycle pulse when the distributor is enabled |

## Verification
The assertions assume that requests are naturally aligned: 64-bit requests use offsets that are multiples of eight, and 32-bit requests use offsets that are multiples of four. They also assume that data beyond the access size does not matter. The bench draws every offset from lists of aligned slot addresses. These cover the control and ID slots, routing slots just inside and just outside the implemented range, and the peripheral-ID window. The bench only ever issues 64-bit requests at offsets with bit 2 clear.

// File: rtl/irq_dist_ctrl_regs.sv
module irq_dist_ctrl_regs #(
  parameter int NUM_SHARED  = 64,
  parameter bit LPI_EN      = 1'b1,
  parameter int ADDR_W      = 16,
  parameter logic [7:0]  PRODUCT     = 8'h4B,
  parameter logic [11:0] IMPLEMENTER = 12'h43B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  output logic              resp_valid,
  output logic [63:0]       resp_rdata,
  output logic              kick
);
  localparam int IDX_W   = (NUM_SHARED > 1) ? $clog2(NUM_SHARED) : 1;
  localparam int LINES   = (NUM_SHARED + 32) / 32 - 1;
  localparam int ID_BITS = LPI_EN ? 16 : 10;
  localparam logic [ADDR_W-1:0] ROUTE_LO = ADDR_W'(32'h6000 + 8 * 32);
  localparam logic [ADDR_W-1:0] ROUTE_HI = ADDR_W'(32'h6000 + 8 * (32 + NUM_SHARED));
  localparam logic [ADDR_W-1:0] PID2_OFS = ADDR_W'(32'hFFE8);
  localparam logic [31:0] TYPE_VAL =
    (32'(ID_BITS - 1) << 19) | (32'(LPI_EN) << 17) | 32'(LINES);
  localparam logic [31:0] IDENT_VAL = {PRODUCT, 12'h000, IMPLEMENTER};

  logic                     grp1_en;
  logic [23:0]              route_q [NUM_SHARED];
  logic [ADDR_W-4:0]        slot;
  logic                     low_hit, route_hit, wr;
  logic [ADDR_W-1:0]        route_off;
  logic [IDX_W-1:0]         route_idx;
  logic [63:0]              slot_val, sel_val;

  assign slot      = req_addr[ADDR_W-1:3];
  assign wr        = req_valid & req_write;
  assign low_hit   = req_wide | ~req_addr[2];
  assign route_hit = (req_addr >= ROUTE_LO) && (req_addr < ROUTE_HI);
  assign route_off = req_addr - ROUTE_LO;
  assign route_idx = route_off[IDX_W+2:3];

  always_comb begin
    slot_val = '0;
    if (slot == '0)
      slot_val = {TYPE_VAL, 25'd0, 1'b1, 1'b0, 1'b1, 2'b00, grp1_en, 1'b0};
    else if (slot == (ADDR_W-3)'(1))
      slot_val = {32'd0, IDENT_VAL};
    else if (route_hit)
      slot_val = {40'd0, route_q[route_idx]};
    else if (slot == PID2_OFS[ADDR_W-1:3])
      slot_val = 64'h3B;
  end

  assign sel_val = req_addr[2] ? {32'd0, slot_val[63:32]} : slot_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp1_en    <= 1'b0;
      kick       <= 1'b0;
      resp_valid <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_valid <= req_valid;
      resp_rdata <= (req_valid && !req_write)
                    ? (req_wide ? sel_val : {32'd0, sel_val[31:0]}) : '0;
      kick       <= wr && slot == '0 && low_hit && !grp1_en && req_wdata[1];
      if (wr && slot == '0 && low_hit)
        grp1_en <= req_wdata[1];
    end
  end

  for (genvar k = 0; k < NUM_SHARED; k++) begin : g_route
    always_ff @(posedge clk) begin
      if (!rst_n)
        route_q[k] <= '0;
      else if (wr && route_hit && low_hit && route_idx == IDX_W'(k))
        route_q[k] <= req_wdata[23:0];
    end
  end
endmodule

// File: rtl/irq_dist_ctrl_regs_chk.sv
module irq_dist_ctrl_regs_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_wide,
  input logic [ADDR_W-1:0] req_addr,
  input logic              resp_valid,
  input logic [63:0]       resp_rdata,
  input logic              kick,
  input logic              grp1_en
);
  a_r12_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);
  a_r12_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);
  a_r12_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> (resp_rdata == 64'd0));
  a_r2_kick_single: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !kick);
  a_r2_kick_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> (grp1_en && resp_valid));
  a_r3_kick_only_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    grp1_en |=> !kick);
  a_r1_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == '0) |=>
      (resp_rdata[6] && resp_rdata[4] && resp_rdata[0] == 1'b0));
  a_r11_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !req_wide) |=> (resp_rdata[63:32] == 32'd0));
endmodule

bind irq_dist_ctrl_regs irq_dist_ctrl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_wide(req_wide), .req_addr(req_addr), .resp_valid(resp_valid),
  .resp_rdata(resp_rdata), .kick(kick), .grp1_en(grp1_en)
);

// File: tb/test_irq_dist_ctrl_regs.sv
`timescale 1ns/1ps
module test_irq_dist_ctrl_regs;
  localparam int NS = 64;
  localparam logic [31:0] TYPE_EXP  = (32'd15 << 19) | (32'd1 << 17) | 32'd2;
  localparam logic [31:0] IDENT_EXP = 32'h4B00_043B;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0, req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
  logic [15:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        resp_valid, kick;
  logic [63:0] resp_rdata;

  irq_dist_ctrl_regs i_irq_dist_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata), .kick(kick));

  int checks = 0, errors = 0;
  logic en_m;
  logic [23:0] route_m [NS];

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_read(input bit wide, input logic [15:0] a);
    logic [63:0] s, r;
    int n;
    s = '0;
    n = int'(a) - 16'h6000;
    if (a[15:3] == 0)      s = {TYPE_EXP, 32'h50 | (32'(en_m) << 1)};
    else if (a[15:3] == 1) s = {32'd0, IDENT_EXP};
    else if (a >= 16'h6000 && a < 16'h8000 && n / 8 >= 32 && n / 8 < 32 + NS)
      s = {40'd0, route_m[n / 8 - 32]};
    else if ({a[15:3], 3'b000} == 16'hFFE8) s = 64'h3B;
    r = a[2] ? {32'd0, s[63:32]} : s;
    return wide ? r : {32'd0, r[31:0]};
  endfunction

  task automatic xfer(input string req, input bit wr, input bit wide,
                      input logic [15:0] a, input logic [63:0] d);
    logic [63:0] exp_rd;
    logic exp_kick;
    int n;
    exp_rd   = wr ? 64'd0 : exp_read(wide, a);
    exp_kick = wr && a[15:3] == 0 && (wide || !a[2]) && !en_m && d[1];
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_wide = wide; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " R12 resp_valid"}, 64'(resp_valid), 64'd1);
    check({req, " data"}, resp_rdata, exp_rd);
    check({req, " R2 kick"}, 64'(kick), 64'(exp_kick));
    if (wr && (wide || !a[2])) begin
      n = int'(a) - 16'h6000;
      if (a[15:3] == 0) en_m = d[1];
      else if (a >= 16'h6000 && a < 16'h8000 && n / 8 >= 32 && n / 8 < 32 + NS)
        route_m[n / 8 - 32] = d[23:0];
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    en_m = 1'b0;
    for (int k = 0; k < NS; k++) route_m[k] = '0;
  endtask

  function automatic logic [15:0] route_addr(input int n);
    return 16'(32'h6000 + 8 * n);
  endfunction

  bit done = 1'b0;
  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] a;
    void'($urandom(32'h5EED_0042));
    do_reset();
    @(negedge clk);
    check("R12 idle resp_valid after reset", 64'(resp_valid), 64'd0);
    check("R2 kick after reset", 64'(kick), 64'd0);
    xfer("R1 ctrl reset value", 0, 0, 16'h0000, 0);
    xfer("R13 route reset", 0, 0, route_addr(40), 0);
    xfer("R1 ctrl write all ones", 1, 0, 16'h0000, 64'hFFFF_FFFF);
    xfer("R1 ctrl readback", 0, 0, 16'h0000, 0);
    xfer("R2 enable again no kick", 1, 0, 16'h0000, 64'h2);
    xfer("R3 disable", 1, 0, 16'h0000, 64'h0);
    xfer("R3 ctrl after disable", 0, 0, 16'h0000, 0);
    xfer("R2 enable by wide write", 1, 1, 16'h0000, 64'hFFFF_FFFF_0000_0002);
    xfer("R4 R5 type", 0, 0, 16'h0004, 0);
    xfer("R6 type write ignored", 1, 0, 16'h0004, 64'h0);
    xfer("R6 type after write", 0, 0, 16'h0004, 0);
    xfer("R6 ident", 0, 0, 16'h0008, 0);
    xfer("R6 ident write ignored", 1, 0, 16'h0008, 64'h0);
    xfer("R6 ident after write", 0, 0, 16'h0008, 0);
    xfer("R11 wide ctrl slot", 0, 1, 16'h0000, 0);
    xfer("R7 route first write", 1, 0, route_addr(32), 64'hFFFF_FFFF);
    xfer("R7 route first read", 0, 0, route_addr(32), 0);
    xfer("R8 route upper write ignored", 1, 0, route_addr(32) + 4, 64'h1234);
    xfer("R8 route upper read", 0, 0, route_addr(32) + 4, 0);
    xfer("R8 route wide write", 1, 1, route_addr(31 + NS), 64'hDEAD_BEEF_CAFE_F00D);
    xfer("R8 route wide read", 0, 1, route_addr(31 + NS), 0);
    xfer("R9 private slot write", 1, 0, route_addr(31), 64'hABCDEF);
    xfer("R9 private slot read", 0, 0, route_addr(31), 0);
    xfer("R9 beyond slot write", 1, 0, route_addr(32 + NS), 64'hABCDEF);
    xfer("R9 beyond slot read", 0, 0, route_addr(32 + NS), 0);
    xfer("R9 neighbour intact", 0, 0, route_addr(31 + NS), 0);
    xfer("R10 pid2", 0, 0, 16'hFFE8, 0);
    xfer("R10 pid other", 0, 0, 16'hFFE0, 0);
    xfer("R10 unmapped", 0, 0, 16'h0100, 0);

    for (int i = 0; i < 600; i++) begin
      int pick, n;
      bit wr, wide;
      pick = int'($urandom_range(0, 9));
      wr   = $urandom_range(0, 1) == 1;
      wide = $urandom_range(0, 2) == 0;
      case (pick)
        0, 1:    a = 16'h0000;
        2:       a = 16'h0004;
        3:       a = 16'h0008;
        4:       a = 16'hFFD0 + 16'(4 * $urandom_range(0, 11));
        default: begin
          n = int'($urandom_range(28, 36 + NS));
          a = route_addr(n) + (($urandom_range(0, 3) == 0) ? 16'd4 : 16'd0);
        end
      endcase
      if (wide) a[2] = 1'b0;
      xfer("R7 R11 random", wr, wide, a,
           {$urandom(), ($urandom_range(0, 1) == 1) ? $urandom() : 32'h2});
    end

    xfer("R13 setup route", 1, 0, route_addr(50), 64'h00AA55);
    do_reset();
    xfer("R13 route after reset", 0, 0, route_addr(50), 0);
    xfer("R13 ctrl after reset", 0, 0, 16'h0000, 0);
    xfer("R2 enable after reset", 1, 0, 16'h0000, 64'h2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule